// File: doc/BRIEF.md
# Gated Event Counter Channel

This block is one counter channel. It watches a single-bit event line, picks either its rising or its falling transitions, and adds one to a 16-bit count for each one it accepts. A second single-bit line, the gate, decides when events are accepted. The gate can be ignored, in which case a software start opens the channel. It can act as a level enable of either polarity. It can also act as a one-time trigger, armed until a chosen gate edge appears.

A programmable compare value sets the terminal count. When the count reaches that value, the output line either gives a one-clock pulse or flips its level. After terminal count, the next accepted event brings the count back to 1, so the output repeats every compare-value events. A compare value of 0 gives a period of 65,536 events.

Both lines arrive from outside the clock domain and pass through a synchronizer before edges are found. Software reads the count through a snapshot register, which is loaded by a read strobe, so counting never pauses for a read.

Top module: `evt_counter_top`

## Requirements
- R1: After reset the snapshot read value is 0, the output is low and the internal count is 0.
- R2: The source-edge select (cfg_src_fall, 0 = rising, 1 = falling) picks the one edge kind that adds exactly one to the count. The other edge kind is ignored.
- R3: With gate mode 0 (no gate), no events are counted after a clear until a software start pulse is given. From then on every active source edge counts.
- R4: With gate mode 1 (level), events count only while the synchronized gate is at the active level (cfg_gate_pol 0 = high, 1 = low). At the other level the count is frozen.
- R5: With gate mode 2 (edge trigger), no events count until the chosen gate edge is seen (cfg_gate_pol 0 = rising, 1 = falling). After that, counting continues whatever the gate level.
- R6: In pulse mode (cfg_out_toggle 0), the output is high for exactly one clock each time the count reaches the compare value. The next accepted event sets the count to 1.
- R7: In toggle mode (cfg_out_toggle 1), the output flips level each time the count reaches the compare value, and it holds its level between those times.
- R8: A clear pulse sets the count to 0 and drives the output low. In edge-trigger mode it also re-arms the channel, so a fresh gate edge is needed before counting resumes.
- R9: rd_count shows the count as sampled on the most recent read strobe, from the following clock onward. It keeps that value until the next strobe while counting goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration inputs below |
| cfg_src_fall | input | 1 | Source edge select: 0 rising, 1 falling |
| cfg_gate_mode | input | 2 | 0 none, 1 level, 2 edge trigger, 3 treated as none |
| cfg_gate_pol | input | 1 | Gate active level or edge: 0 high/rising, 1 low/falling |
| cfg_out_toggle | input | 1 | Output mode: 0 pulse, 1 toggle |
| cfg_tc | input | 16 | Terminal count compare value |
| sw_start | input | 1 | Software start pulse for ungated mode |
| sw_clear | input | 1 | Clear count and output; re-arm the edge trigger |
| rd_strobe | input | 1 | Load the count snapshot |
| rd_count | output | 16 | Snapshot of the count |
| src_in | input | 1 | Event source line, asynchronous |
| gate_in | input | 1 | Gate line, asynchronous |
| cnt_out | output | 1 | Terminal count output |

## Verification
Suppose the gate state goes wrong, for example a lost trigger flag or a stuck run flag. The snapshot will then show a count that differs from the number of edges driven. This shows on the first read after a burst, about four clocks after the last edge. A wrong compare or reload step shows in the output within one clock of the expected terminal event: a pulse appears in the wrong place, a pulse is missing, or a toggle level is wrong. The count after wrap will also read wrong. A snapshot that updates without a strobe shows as a changed rd_count between reads.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        GATE_NONE  = 2'd0,
        GATE_LEVEL = 2'd1,
        GATE_EDGE  = 2'd2,
        GATE_RSVD  = 2'd3
    } gate_mode_e;

    typedef struct packed {
        logic       src_fall;
        gate_mode_e gmode;
        logic       gpol;
        logic       out_toggle;
    } chan_cfg_t;

endpackage

// File: rtl/evc_sync_stage.sv
module evc_sync_stage #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic prev
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], din};
        st_d.last = st_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign prev  = st_q.last;
endmodule

// File: rtl/evc_gate_ctrl.sv
module evc_gate_ctrl
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gate_mode_e gmode,
    input  logic       gpol,
    input  logic       g_level,
    input  logic       g_rise,
    input  logic       g_fall,
    input  logic       sw_start,
    input  logic       sw_clear,
    output logic       enable
);
    typedef struct packed {
        logic run;
        logic trig;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     trig_edge;

    always_comb begin
        trig_edge = gpol ? g_fall : g_rise;
        st_d      = st_q;
        if (sw_clear) begin
            st_d.run  = 1'b0;
            st_d.trig = 1'b0;
        end else begin
            if (sw_start) st_d.run = 1'b1;
            if (gmode == GATE_EDGE && trig_edge) st_d.trig = 1'b1;
        end
        unique case (gmode)
            GATE_LEVEL: enable = g_level ^ gpol;
            GATE_EDGE:  enable = st_q.trig;
            default:    enable = st_q.run;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: the trigger flag can only become set in edge mode on the chosen gate edge
    a_r5_arm_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.trig) |-> $past(gmode) == GATE_EDGE
                             && ($past(gpol) ? $past(g_fall) : $past(g_rise)));
endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clear,
    input  logic [CNT_W-1:0] tc,
    input  logic             toggle_mode,
    output logic [CNT_W-1:0] count,
    output logic             out
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             out;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] step_val;
    logic             hit;

    always_comb begin
        step_val = (st_q.count == tc) ? CNT_W'(1) : st_q.count + CNT_W'(1);
        hit      = evt && (step_val == tc);
        st_d     = st_q;
        if (clear) begin
            st_d.count = '0;
            st_d.out   = 1'b0;
        end else begin
            if (evt) st_d.count = step_val;
            if (toggle_mode) st_d.out = hit ? ~st_q.out : st_q.out;
            else             st_d.out = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign out   = st_q.out;

    // R2: outside a clear the count moves by one step or restarts at 1
    a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.count) && !$past(clear))
            |-> (st_q.count == $past(st_q.count) + CNT_W'(1)) || (st_q.count == CNT_W'(1)));

    // R6: a pulse-mode output never stays high for two clocks
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out && !toggle_mode) |=> (!st_q.out || toggle_mode));

    // R7: in toggle mode the output level moves only when terminal count is reached
    a_r7_toggle_at_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_mode && $past(toggle_mode) && !$past(clear) && $stable(tc)
         && !$stable(st_q.out)) |-> st_q.count == tc);

    // R8: clear leaves a zero count and a low output
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.count == '0) && !st_q.out);
endmodule

// File: rtl/evt_counter_top.sv
module evt_counter_top
    import evc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_src_fall,
    input  logic [1:0]       cfg_gate_mode,
    input  logic             cfg_gate_pol,
    input  logic             cfg_out_toggle,
    input  logic [CNT_W-1:0] cfg_tc,
    input  logic             sw_start,
    input  logic             sw_clear,
    input  logic             rd_strobe,
    output logic [CNT_W-1:0] rd_count,
    input  logic             src_in,
    input  logic             gate_in,
    output logic             cnt_out
);
    localparam int N_LINES  = 2;
    localparam int IDX_SRC  = 0;
    localparam int IDX_GATE = 1;

    typedef struct packed {
        chan_cfg_t        cfg;
        logic [CNT_W-1:0] tc;
        logic [CNT_W-1:0] snap;
    } top_st_t;

    top_st_t              st_d, st_q;
    logic [N_LINES-1:0]   raw_in, lvl, prv, rise, fall;
    logic                 gate_en, src_evt;
    logic [CNT_W-1:0]     count;

    assign raw_in = {gate_in, src_in};

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        evc_sync_stage #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_in[i]),
            .level (lvl[i]),
            .prev  (prv[i])
        );
        assign rise[i] = lvl[i] & ~prv[i];
        assign fall[i] = ~lvl[i] & prv[i];
    end

    evc_gate_ctrl u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gmode    (st_q.cfg.gmode),
        .gpol     (st_q.cfg.gpol),
        .g_level  (lvl[IDX_GATE]),
        .g_rise   (rise[IDX_GATE]),
        .g_fall   (fall[IDX_GATE]),
        .sw_start (sw_start),
        .sw_clear (sw_clear),
        .enable   (gate_en)
    );

    assign src_evt = gate_en && (st_q.cfg.src_fall ? fall[IDX_SRC] : rise[IDX_SRC]);

    evc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (src_evt),
        .clear       (sw_clear),
        .tc          (st_q.tc),
        .toggle_mode (st_q.cfg.out_toggle),
        .count       (count),
        .out         (cnt_out)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            st_d.cfg.src_fall   = cfg_src_fall;
            st_d.cfg.gmode      = gate_mode_e'(cfg_gate_mode);
            st_d.cfg.gpol       = cfg_gate_pol;
            st_d.cfg.out_toggle = cfg_out_toggle;
            st_d.tc             = cfg_tc;
        end
        if (rd_strobe) st_d.snap = count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_count = st_q.snap;

    // R4: at the inactive gate level the count does not move
    a_r4_level_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.gmode == GATE_LEVEL && (lvl[IDX_GATE] == st_q.cfg.gpol) && !sw_clear)
            |=> $stable(count));

    // R9: the snapshot holds between read strobes
    a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_count));

    // R1: values seen on the first clock after reset release
    a_r1_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_count == '0) && !cnt_out);
endmodule

// File: tb/evt_counter_top_tb_top.sv
module evt_counter_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_src_fall = 1'b0, cfg_gate_pol = 1'b0, cfg_out_toggle = 1'b0;
    logic [1:0]  cfg_gate_mode = 2'd0;
    logic [15:0] cfg_tc = 16'd0;
    logic        sw_start = 1'b0, sw_clear = 1'b0, rd_strobe = 1'b0;
    logic        src_in = 1'b0, gate_in = 1'b0;
    logic [15:0] rd_count;
    logic        cnt_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int hi_cycles = 0;
    bit done = 1'b0;
    logic [15:0] v;

    always #10 clk = ~clk;

    evt_counter_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src_fall(cfg_src_fall),
        .cfg_gate_mode(cfg_gate_mode), .cfg_gate_pol(cfg_gate_pol),
        .cfg_out_toggle(cfg_out_toggle), .cfg_tc(cfg_tc), .sw_start(sw_start),
        .sw_clear(sw_clear), .rd_strobe(rd_strobe), .rd_count(rd_count),
        .src_in(src_in), .gate_in(gate_in), .cnt_out(cnt_out)
    );

    typedef struct packed {
        logic        sf;
        logic [1:0]  gm;
        logic        gp;
        logic        gl;
        logic [7:0]  n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 8'd5, 16'd5},
        '{1'b1, 2'd0, 1'b0, 1'b0, 8'd4, 16'd4},
        '{1'b0, 2'd1, 1'b0, 1'b1, 8'd6, 16'd6},
        '{1'b0, 2'd1, 1'b0, 1'b0, 8'd6, 16'd0},
        '{1'b0, 2'd1, 1'b1, 1'b0, 8'd3, 16'd3},
        '{1'b1, 2'd1, 1'b1, 1'b1, 8'd3, 16'd0},
        '{1'b1, 2'd1, 1'b0, 1'b1, 8'd7, 16'd7},
        '{1'b0, 2'd3, 1'b0, 1'b0, 8'd2, 16'd2}
    };

    always @(negedge clk) if (cnt_out) hi_cycles++;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
            summary();
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg(logic sf, logic [1:0] gm, logic gp, logic tg, logic [15:0] tc);
        @(negedge clk);
        cfg_src_fall = sf; cfg_gate_mode = gm; cfg_gate_pol = gp;
        cfg_out_toggle = tg; cfg_tc = tc; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) sw_clear = 1'b1;
        @(negedge clk) sw_clear = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk) sw_start = 1'b1;
        @(negedge clk) sw_start = 1'b0;
    endtask

    task automatic set_gate(logic g);
        @(negedge clk) gate_in = g;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) src_in = 1'b1;
            @(negedge clk);
            @(negedge clk) src_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic rd(output logic [15:0] val);
        repeat (4) @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
        val = rd_count;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_count after reset", rd_count, 0);
        chk("R1 cnt_out after reset", cnt_out, 0);
        rd(v);
        chk("R1 count read after reset", v, 0);

        // vector table: R2 edge select, R4 level gating
        for (int i = 0; i < NV; i++) begin
            cfg(VECS[i].sf, VECS[i].gm, VECS[i].gp, 1'b0, 16'd0);
            set_gate(VECS[i].gl);
            do_clear();
            do_start();
            pulses(int'(VECS[i].n));
            rd(v);
            chk($sformatf("R2/R4 vector %0d", i), v, VECS[i].exp);
        end

        // R3: no start, no counting
        cfg(1'b0, 2'd0, 1'b0, 1'b0, 16'd0);
        do_clear();
        pulses(3);
        rd(v);
        chk("R3 before start", v, 0);
        do_start();
        pulses(3);
        rd(v);
        chk("R3 after start", v, 3);

        // R5: rising-edge trigger
        cfg(1'b0, 2'd2, 1'b0, 1'b0, 16'd0);
        set_gate(1'b0);
        do_clear();
        pulses(3);
        rd(v);
        chk("R5 waiting for gate edge", v, 0);
        set_gate(1'b1);
        pulses(4);
        rd(v);
        chk("R5 after rising gate", v, 4);
        set_gate(1'b0);
        pulses(2);
        rd(v);
        chk("R5 continues with gate low", v, 6);

        // R8: clear re-arms trigger
        do_clear();
        rd(v);
        chk("R8 clear zeroes count", v, 0);
        pulses(2);
        rd(v);
        chk("R8 re-armed, no gate edge", v, 0);
        set_gate(1'b1);
        pulses(1);
        rd(v);
        chk("R8 fresh gate edge", v, 1);

        // R5: falling-edge trigger
        cfg(1'b0, 2'd2, 1'b1, 1'b0, 16'd0);
        do_clear();
        pulses(2);
        rd(v);
        chk("R5 falling waits", v, 0);
        set_gate(1'b0);
        pulses(3);
        rd(v);
        chk("R5 after falling gate", v, 3);

        // R9: snapshot holds without strobe
        pulses(2);
        repeat (6) @(negedge clk);
        chk("R9 snapshot holds", rd_count, 3);
        rd(v);
        chk("R9 new snapshot", v, 5);

        // R6: pulse mode, compare 3
        cfg(1'b0, 2'd0, 1'b0, 1'b0, 16'd3);
        do_clear();
        do_start();
        hi_cycles = 0;
        pulses(3);
        rd(v);
        chk("R6 count at tc", v, 3);
        chk("R6 one high cycle", hi_cycles, 1);
        chk("R6 output low after pulse", cnt_out, 0);
        pulses(1);
        rd(v);
        chk("R6 restart at 1", v, 1);
        pulses(2);
        rd(v);
        chk("R6 second terminal count", v, 3);
        chk("R6 two high cycles", hi_cycles, 2);

        // R7: toggle mode, compare 2
        cfg(1'b0, 2'd0, 1'b0, 1'b1, 16'd2);
        do_clear();
        do_start();
        pulses(2);
        rd(v);
        chk("R7 first toggle", cnt_out, 1);
        pulses(1);
        rd(v);
        chk("R7 holds between tc", cnt_out, 1);
        chk("R7 count restarted", v, 1);
        pulses(1);
        rd(v);
        chk("R7 second toggle", cnt_out, 0);
        pulses(2);
        rd(v);
        chk("R7 third toggle", cnt_out, 1);
        do_clear();
        @(negedge clk);
        chk("R8 clear drives output low", cnt_out, 0);

        done = 1'b1;
        summary();
    end
endmodule